// File: doc/BRIEF.md
# Power-Good and Overvoltage Threshold Logic

This block follows the operating phase of a multi-phase voltage regulator controller. From it, the block decides two things. The first is whether the open-drain power-good output may be released. The second is which overvoltage trip level applies at the moment. It takes flags for the supply rail (fully valid, or only above the 1.4 V auxiliary level), the enable and the soft-start-done indication. It also takes the target voltage code and two digitized voltages: the raw sense pin and the differential remote-sense amplifier output.

All voltages are codes in one shared LSB. With the default parameters that LSB is 5 mV, so 1.8 V is 360, 1.7 V is 340 and a 200 mV margin is 40. The block returns four outputs. The power-good release is active high. The threshold code in use is one bit wider than the voltage codes, so the target plus the margin never wraps. The overvoltage trip flag latches. The undervoltage flag is registered. The comparators, the open-drain driver and the actions taken after an overvoltage trip live outside this block.

Four phases exist. Down means the supply is not valid. Idle means the supply is valid but the controller is not running. Ramp is soft start. Live is normal regulation. The controller runs only when the supply is valid, the enable is high and the target code is not the reserved no-load code (zero by default). All inputs are sampled on the rising clock edge. Every registered output reflects that edge, and the threshold output follows the phase register and the live target code.

Top module: `pg_ov_monitor`

## Requirements
- R1: While reset is asserted and until the first sampled input, power-good and both fault flags are 0 and the phase is Down, so the threshold reads the auxiliary level (360).
- R2: Power-good rises only at the edge after soft-start-done is sampled high in Ramp. Ramp is entered from Idle or Down at the edge where the run condition is first sampled true. Power-good stays 0 throughout Ramp.
- R3: The undervoltage flag is 1 exactly when the sense code is strictly below target − (target >> 2). It updates one edge after the inputs are sampled.
- R4: In Live, power-good equals the inverse of the undervoltage flag, so it returns high by itself once the undervoltage clears.
- R5: Power-good falls at the next edge after any of these: enable low, supply not valid, or a target code of 0. Once it has fallen, it rises again only through a new soft start, even if undervoltage has cleared in the meantime.
- R6: A set overvoltage trip flag has no effect on power-good.
- R7: In Down with the auxiliary flag high, the threshold is 360 and is compared against the sense code.
- R8: In Idle the threshold is 340 against the differential code. While the trip flag is latched it is target + 40 instead.
- R9: In Ramp the threshold is the larger of 340 and target + 40.
- R10: In Live the threshold is target + 40.
- R11: The trip flag sets at the edge after the compared code is strictly greater than the active threshold. It stays set until Ramp is entered or until both supply flags are low.
- R12: With both the valid flag and the auxiliary flag low, no overvoltage trip is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_valid | input | 1 | Supply rail fully valid |
| aux_ok | input | 1 | Supply rail above the auxiliary 1.4 V level |
| ctl_enable | input | 1 | Controller enable (all enable sources combined) |
| ss_done | input | 1 | Soft-start ramp has reached the target |
| target_code | input | W | Target voltage code; 0 is the no-load code |
| sense_code | input | W | Digitized sense-pin voltage |
| diff_code | input | W | Digitized differential amplifier voltage |
| pgood_rel | output | 1 | Release power-good (1 = let the pin go high) |
| ov_thresh | output | W+1 | Overvoltage threshold code in force |
| ov_trip | output | 1 | Latched overvoltage trip |
| uv_flag | output | 1 | Undervoltage detected |

## Verification
The undervoltage compare and the overvoltage compare can both fire on one edge in Live. The bench provokes this by driving a low sense code and a high differential code in the same cycle. It then judges that power-good falls for the undervoltage alone, and that power-good comes back once sense recovers while the trip flag stays set. A second collision pairs an active undervoltage with a disable on the same edge. That case must keep power-good low after the undervoltage clears, until a fresh soft start completes.

// File: rtl/pg_mon_pkg.sv
`timescale 1ns/1ps
package pg_mon_pkg;

  typedef enum logic [1:0] {
    PH_DOWN = 2'd0,
    PH_IDLE = 2'd1,
    PH_RAMP = 2'd2,
    PH_LIVE = 2'd3
  } phase_e;

endpackage

// File: rtl/pg_phase_fsm.sv
`timescale 1ns/1ps
module pg_phase_fsm
  import pg_mon_pkg::*;
#(
  parameter int W          = 10,
  parameter int NOLOAD_CODE = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         supply_valid,
  input  logic         ctl_enable,
  input  logic         ss_done,
  input  logic [W-1:0] target_code,
  output phase_e       phase_q,
  output logic         ramp_start
);

  localparam logic [W-1:0] NOLOAD_C = W'(NOLOAD_CODE);

  phase_e phase_d;
  logic   run_req;
  logic   phase_en;

  always_comb begin
    run_req = supply_valid && ctl_enable && (target_code != NOLOAD_C);
    phase_d = phase_q;
    if (!supply_valid) begin
      phase_d = PH_DOWN;
    end else if (!run_req) begin
      phase_d = PH_IDLE;
    end else begin
      case (phase_q)
        PH_DOWN, PH_IDLE: phase_d = PH_RAMP;
        PH_RAMP:          phase_d = ss_done ? PH_LIVE : PH_RAMP;
        default:          phase_d = PH_LIVE;
      endcase
    end
    phase_en   = (phase_d != phase_q);
    ramp_start = (phase_d == PH_RAMP) && (phase_q != PH_RAMP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_DOWN;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/pg_ov_guard.sv
`timescale 1ns/1ps
module pg_ov_guard
  import pg_mon_pkg::*;
#(
  parameter int W           = 10,
  parameter int AUX_LIMIT   = 360,
  parameter int IDLE_LIMIT  = 340,
  parameter int OV_MARGIN   = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  phase_e       phase_q,
  input  logic         ramp_start,
  input  logic         supply_valid,
  input  logic         aux_ok,
  input  logic [W-1:0] target_code,
  input  logic [W-1:0] sense_code,
  input  logic [W-1:0] diff_code,
  output logic [W:0]   ov_thresh,
  output logic         ov_trip,
  output logic         trip_clr
);

  localparam logic [W:0] AUX_C    = (W+1)'(AUX_LIMIT);
  localparam logic [W:0] IDLE_C   = (W+1)'(IDLE_LIMIT);
  localparam logic [W:0] MARGIN_C = (W+1)'(OV_MARGIN);

  logic [W:0]   tgt_plus;
  logic [W:0]   ramp_lvl;
  logic [W-1:0] probe;
  logic         armed;
  logic         hit;
  logic         trip_q;
  logic         trip_d;
  logic         trip_en;

  always_comb begin
    tgt_plus = {1'b0, target_code} + MARGIN_C;
    ramp_lvl = (tgt_plus > IDLE_C) ? tgt_plus : IDLE_C;
    case (phase_q)
      PH_DOWN: begin
        ov_thresh = AUX_C;
        probe     = sense_code;
        armed     = aux_ok;
      end
      PH_IDLE: begin
        ov_thresh = trip_q ? tgt_plus : IDLE_C;
        probe     = diff_code;
        armed     = 1'b1;
      end
      PH_RAMP: begin
        ov_thresh = ramp_lvl;
        probe     = diff_code;
        armed     = 1'b1;
      end
      default: begin
        ov_thresh = tgt_plus;
        probe     = diff_code;
        armed     = 1'b1;
      end
    endcase
    hit      = armed && ({1'b0, probe} > ov_thresh);
    trip_clr = ramp_start || (!supply_valid && !aux_ok);
    trip_en  = trip_clr || hit;
    trip_d   = !trip_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q <= 1'b0;
    end else if (trip_en) begin
      trip_q <= trip_d;
    end
  end

  assign ov_trip = trip_q;

endmodule

// File: rtl/pg_uv_watch.sv
`timescale 1ns/1ps
module pg_uv_watch #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] target_code,
  input  logic [W-1:0] sense_code,
  output logic         uv_flag
);

  logic [W-1:0] floor_code;
  logic         uv_d;
  logic         uv_q;
  logic         uv_en;

  always_comb begin
    floor_code = target_code - (target_code >> 2);
    uv_d       = (sense_code < floor_code);
    uv_en      = (uv_d != uv_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_q <= 1'b0;
    end else if (uv_en) begin
      uv_q <= uv_d;
    end
  end

  assign uv_flag = uv_q;

endmodule

// File: rtl/pg_ov_monitor.sv
`timescale 1ns/1ps
module pg_ov_monitor
  import pg_mon_pkg::*;
#(
  parameter int W           = 10,
  parameter int AUX_LIMIT   = 360,
  parameter int IDLE_LIMIT  = 340,
  parameter int OV_MARGIN   = 40,
  parameter int NOLOAD_CODE = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         supply_valid,
  input  logic         aux_ok,
  input  logic         ctl_enable,
  input  logic         ss_done,
  input  logic [W-1:0] target_code,
  input  logic [W-1:0] sense_code,
  input  logic [W-1:0] diff_code,
  output logic         pgood_rel,
  output logic [W:0]   ov_thresh,
  output logic         ov_trip,
  output logic         uv_flag
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  phase_e                 phase_q;
  logic                   ramp_start;
  logic                   trip_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  pg_phase_fsm #(
    .W          (W),
    .NOLOAD_CODE(NOLOAD_CODE)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .supply_valid(supply_valid),
    .ctl_enable  (ctl_enable),
    .ss_done     (ss_done),
    .target_code (target_code),
    .phase_q     (phase_q),
    .ramp_start  (ramp_start)
  );

  pg_ov_guard #(
    .W         (W),
    .AUX_LIMIT (AUX_LIMIT),
    .IDLE_LIMIT(IDLE_LIMIT),
    .OV_MARGIN (OV_MARGIN)
  ) u_ov (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .phase_q     (phase_q),
    .ramp_start  (ramp_start),
    .supply_valid(supply_valid),
    .aux_ok      (aux_ok),
    .target_code (target_code),
    .sense_code  (sense_code),
    .diff_code   (diff_code),
    .ov_thresh   (ov_thresh),
    .ov_trip     (ov_trip),
    .trip_clr    (trip_clr)
  );

  pg_uv_watch #(
    .W(W)
  ) u_uv (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .target_code(target_code),
    .sense_code (sense_code),
    .uv_flag    (uv_flag)
  );

  assign pgood_rel = (phase_q == PH_LIVE) && !uv_flag;

endmodule

// File: rtl/pg_ov_monitor_chk.sv
`timescale 1ns/1ps
module pg_ov_monitor_chk #(
  parameter int W          = 10,
  parameter int AUX_LIMIT  = 360,
  parameter int OV_MARGIN  = 40
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         supply_valid,
  input logic         aux_ok,
  input logic         ctl_enable,
  input logic [W-1:0] target_code,
  input logic         pgood_rel,
  input logic [W:0]   ov_thresh,
  input logic         ov_trip,
  input logic         uv_flag,
  input logic         trip_clr
);

  localparam logic [W:0] AUX_C    = (W+1)'(AUX_LIMIT);
  localparam logic [W:0] MARGIN_C = (W+1)'(OV_MARGIN);

  AST_PG_BLOCKED_BY_UV: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pgood_rel |-> !uv_flag); // R4

  AST_PG_DROP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctl_enable || !supply_valid) |=> !pgood_rel); // R5

  AST_AUX_THRESH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !supply_valid |=> (ov_thresh == AUX_C)); // R7

  AST_LIVE_THRESH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pgood_rel |-> (ov_thresh == ({1'b0, target_code} + MARGIN_C))); // R10

  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ov_trip && !trip_clr) |=> ov_trip); // R11

  AST_NO_TRIP_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!supply_valid && !aux_ok) |=> !ov_trip); // R12

endmodule

bind pg_ov_monitor pg_ov_monitor_chk #(
  .W        (W),
  .AUX_LIMIT(AUX_LIMIT),
  .OV_MARGIN(OV_MARGIN)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .supply_valid(supply_valid),
  .aux_ok      (aux_ok),
  .ctl_enable  (ctl_enable),
  .target_code (target_code),
  .pgood_rel   (pgood_rel),
  .ov_thresh   (ov_thresh),
  .ov_trip     (ov_trip),
  .uv_flag     (uv_flag),
  .trip_clr    (trip_clr)
);

// File: tb/sim_pg_ov_monitor.sv
`timescale 1ns/1ps
module sim_pg_ov_monitor;

  localparam int W = 10;

  logic         clk;
  logic         rst_n;
  logic         supply_valid;
  logic         aux_ok;
  logic         ctl_enable;
  logic         ss_done;
  logic [W-1:0] target_code;
  logic [W-1:0] sense_code;
  logic [W-1:0] diff_code;
  logic         pgood_rel;
  logic [W:0]   ov_thresh;
  logic         ov_trip;
  logic         uv_flag;

  int n_chk;
  int n_bad;
  bit done;

  // {target, sense, expected undervoltage}
  localparam logic [20:0] UV_VEC [0:5] = '{
    {10'd270,  10'd202, 1'b1},
    {10'd270,  10'd203, 1'b0},
    {10'd4,    10'd2,   1'b1},
    {10'd4,    10'd3,   1'b0},
    {10'd1023, 10'd767, 1'b1},
    {10'd1023, 10'd768, 1'b0}
  };

  pg_ov_monitor u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_valid(supply_valid),
    .aux_ok      (aux_ok),
    .ctl_enable  (ctl_enable),
    .ss_done     (ss_done),
    .target_code (target_code),
    .sense_code  (sense_code),
    .diff_code   (diff_code),
    .pgood_rel   (pgood_rel),
    .ov_thresh   (ov_thresh),
    .ov_trip     (ov_trip),
    .uv_flag     (uv_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; supply_valid = 1'b0; aux_ok = 1'b0; ctl_enable = 1'b0;
    ss_done = 1'b0; target_code = '0; sense_code = '0; diff_code = '0;
    #1;
    chk("R1 pgood in reset", pgood_rel, 0);
    chk("R1 trip in reset", ov_trip, 0);
    chk("R1 uv in reset", uv_flag, 0);
    chk("R1 thresh in reset", ov_thresh, 360);
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R12: fully unpowered, large sense does not trip
    sense_code = 10'd1000;
    tick(); tick();
    chk("R12 no trip unpowered", ov_trip, 0);

    // R7: auxiliary level on sense, strict compare
    aux_ok = 1'b1; sense_code = 10'd360;
    tick();
    chk("R7 thresh aux", ov_thresh, 360);
    chk("R11 equal does not trip", ov_trip, 0);
    sense_code = 10'd361;
    tick();
    chk("R11 trip above aux", ov_trip, 1);
    aux_ok = 1'b0; sense_code = '0;
    tick();
    chk("R11 cleared by full loss", ov_trip, 0);

    // R8: idle thresholds
    aux_ok = 1'b1; supply_valid = 1'b1; target_code = 10'd270; sense_code = 10'd270;
    tick();
    chk("R8 idle thresh", ov_thresh, 340);
    diff_code = 10'd341;
    tick();
    chk("R8 idle trip", ov_trip, 1);
    chk("R8 idle thresh after trip", ov_thresh, 310);
    diff_code = '0;
    tick(); tick();
    chk("R11 trip held in idle", ov_trip, 1);

    // R2/R9: soft start
    ctl_enable = 1'b1;
    tick();
    chk("R11 cleared on ramp", ov_trip, 0);
    chk("R9 ramp thresh low target", ov_thresh, 340);
    chk("R2 no pgood in ramp", pgood_rel, 0);
    target_code = 10'd320;
    tick();
    chk("R9 ramp thresh high target", ov_thresh, 360);
    target_code = 10'd270;
    tick();
    chk("R2 still low before done", pgood_rel, 0);
    ss_done = 1'b1;
    tick();
    chk("R2 pgood after done", pgood_rel, 1);
    chk("R10 live thresh", ov_thresh, 310);

    // R6/R11 in live
    diff_code = 10'd310;
    tick();
    chk("R11 live equal no trip", ov_trip, 0);
    diff_code = 10'd311;
    tick();
    chk("R11 live trip", ov_trip, 1);
    chk("R6 pgood ignores ov", pgood_rel, 1);
    diff_code = '0;
    tick();
    chk("R11 live trip held", ov_trip, 1);

    // R3/R4: undervoltage vectors while live
    for (int i = 0; i < 6; i++) begin
      target_code = UV_VEC[i][20:11];
      sense_code  = UV_VEC[i][10:1];
      tick();
      chk("R3 uv vector", uv_flag, int'(UV_VEC[i][0]));
      chk("R4 pgood vs uv", pgood_rel, int'(!UV_VEC[i][0]));
    end
    target_code = 10'd270; sense_code = 10'd270;
    tick();

    // R5/R8: disable, then fresh soft start
    ctl_enable = 1'b0;
    tick();
    chk("R5 pgood off on disable", pgood_rel, 0);
    chk("R8 idle thresh tripped", ov_thresh, 310);
    ss_done = 1'b0; ctl_enable = 1'b1;
    tick();
    chk("R2 ramp again", pgood_rel, 0);
    chk("R11 cleared on re-ramp", ov_trip, 0);
    ss_done = 1'b1;
    tick();
    chk("R2 pgood back", pgood_rel, 1);

    // UV and OV on the same edge
    sense_code = 10'd100; diff_code = 10'd400;
    tick();
    chk("R3 uv with ov", uv_flag, 1);
    chk("R11 ov with uv", ov_trip, 1);
    chk("R4 pgood low from uv", pgood_rel, 0);
    sense_code = 10'd270; diff_code = '0;
    tick();
    chk("R6 pgood back with trip set", pgood_rel, 1);
    chk("R11 trip kept", ov_trip, 1);

    // UV and disable on the same edge
    sense_code = 10'd100;
    tick();
    chk("R4 uv pulls low", pgood_rel, 0);
    ctl_enable = 1'b0; sense_code = 10'd270;
    tick(); tick();
    chk("R3 uv cleared", uv_flag, 0);
    chk("R5 stays low after uv clears", pgood_rel, 0);
    ss_done = 1'b0; ctl_enable = 1'b1;
    tick();
    ss_done = 1'b1;
    tick();
    chk("R2 recovers via ramp", pgood_rel, 1);

    // R5: no-load code
    target_code = '0;
    tick();
    chk("R5 no-load code", pgood_rel, 0);
    chk("R8 idle thresh clean", ov_thresh, 340);

    // R5/R7: supply drop
    target_code = 10'd270;
    tick(); tick();
    chk("R2 live before drop", pgood_rel, 1);
    supply_valid = 1'b0;
    tick();
    chk("R5 supply drop", pgood_rel, 0);
    chk("R7 thresh after drop", ov_thresh, 360);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule